// File: doc/BRIEF.md
# Trace-Back Survivor Path Decoder

This block turns the stream of survivor decisions produced by an add-compare-select array into decoded bits for a Viterbi decoder with 2^K states. Each decision vector holds one bit per state. When its valid strobe is high, the vector is written into a circular decision memory. The memory is organised as k+1 banks of T/(k-1) columns each, with one column per trellis step.

Each time a bank fills, a single read pointer starts at the newest column and works back from state zero. The pointer makes k reads per clock, which is k times the write rate. It first walks T merge columns, covering k-1 banks, without emitting anything. It then walks one further bank and produces one decoded bit per column. These bits are produced newest first. They are written into one of two small stacks. At the end of the trace the two stacks swap roles, and the filled stack is drained oldest first with a valid strobe. The output therefore comes out in time order.

The defaults are 8 states, k = 3 and T = 8. This gives 4 banks of 4 columns and 16 columns in total. The total column count must be a power of two.

Top module: `viterbi_traceback_mgr`

## Requirements
- R1: After reset `bit_valid` is low. No bit is emitted until k banks have been filled, which is 12 accepted vectors with the defaults.
- R2: A trace step at column c in state s reads bit d = vector(c)[s]. The bit index is the state number, and bit 0 of `dec_vec` belongs to state 0. The next state is {d, s[K-1:1]}, and each trace starts in state 0.
- R3: Each time the last column of a bank is written (column index mod 4 = 3), one trace starts at that column c. It walks columns c down to c-7 as the merge region. It then walks c-8 down to c-11 as the decode region. The decoded bit of a decode column is the most significant bit of the state reached there.
- R4: Decoded bits leave in ascending time order. Each trellis step from 0 onward is emitted exactly once, at a rate of one bit per clock.
- R5: With decisions accepted every clock, the first decoded bit is presented (k+1)T/(k-1) - 1 = 15 clock edges after the edge that captures the first vector.
- R6: `bit_valid` rises only right after a trace completes. Every run of `bit_valid` lasts a multiple of 4 cycles.
- R7: Cycles with `dec_valid` low neither write a column nor advance the write position. The decoded stream equals that of the same vectors sent back to back.
- R8: No write ever lands in a bank that the running trace reads.
- R9: A stack is completely drained before the swap that refills it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decision vector present this cycle |
| dec_vec | input | STATES | One survivor decision bit per state |
| bit_valid | output | 1 | Decoded bit present |
| bit_out | output | 1 | Decoded bit, in time order |

## Verification
The decoder is driven with several decision patterns:
- All-zero and all-one decisions fix the path at constant 0 and 1 outputs. These separate the bit-address and state-shift recursion from stack ordering faults.
- Alternating 0xAA/0x55 words make the decoded bit depend on which state bit was read. This exposes a wrong bit address or shift direction.
- Pseudo-random words, sent both back to back and with random idle gaps, are compared bit by bit against an arithmetic trace model. This covers the reversal by the stacks and the ping-pong timing, and shows that idle cycles leave the result unchanged.

A short run of 8 vectors shows that nothing is emitted before the third bank closes. The continuous run also measures the first-bit latency.

// File: rtl/viterbi_traceback_mgr.sv
module viterbi_traceback_mgr #(
  parameter int STATES = 8,
  parameter int SPEED  = 3,
  parameter int TBLEN  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic [STATES-1:0] dec_vec,
  output logic              bit_valid,
  output logic              bit_out
);
  localparam int SW    = $clog2(STATES);
  localparam int BLK   = TBLEN / (SPEED - 1);
  localparam int BBW   = (BLK > 1) ? $clog2(BLK) : 1;
  localparam int NBANK = SPEED + 1;
  localparam int COLS  = NBANK * BLK;
  localparam int CW    = $clog2(COLS);
  localparam int DW    = (SPEED > 2) ? $clog2(SPEED) : 1;
  localparam int DRW   = $clog2(BLK + 1);

  logic [STATES-1:0] mem [COLS];
  logic [CW-1:0]     wptr, col;
  logic [SW-1:0]     st;
  logic [DW-1:0]     done_cnt;
  logic              busy, sel;
  logic [BBW-1:0]    cyc;
  logic [1:0][BLK-1:0] stk;
  logic [DRW-1:0]    drain;

  wire bank_end = dec_valid && (wptr[BBW-1:0] == BBW'(BLK - 1));
  wire trigger  = bank_end && (done_cnt == DW'(SPEED - 1));
  wire last     = busy && (cyc == BBW'(BLK - 1));

  logic [SW-1:0]    sc [SPEED+1];
  logic [CW-1:0]    cc [SPEED];
  logic [SPEED-1:0] dbit;
  assign sc[0] = st;

  for (genvar g = 0; g < SPEED; g++) begin : g_step
    assign cc[g]    = col - CW'(g);
    assign dbit[g]  = mem[cc[g]][sc[g]];
    assign sc[g+1]  = {dbit[g], sc[g][SW-1:1]};

    AST_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && dec_valid) |-> (cc[g][CW-1:BBW] != wptr[CW-1:BBW])); // R8
  end

  always_ff @(posedge clk)
    if (dec_valid) mem[wptr] <= dec_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0; done_cnt <= '0; busy <= 1'b0; cyc <= '0;
      col <= '0; st <= '0; sel <= 1'b0; drain <= '0; stk <= '0;
    end else begin
      if (dec_valid) wptr <= wptr + 1'b1;
      if (bank_end && done_cnt != DW'(SPEED - 1)) done_cnt <= done_cnt + 1'b1;

      if (trigger) begin
        busy <= 1'b1; cyc <= '0; col <= wptr; st <= '0;
      end else if (busy) begin
        col <= col - CW'(SPEED);
        st  <= sc[SPEED];
        cyc <= cyc + 1'b1;
        if (last) busy <= 1'b0;
      end

      if (busy)
        for (int g = 0; g < SPEED; g++)
          if (int'(cyc) * SPEED + g >= TBLEN)
            stk[sel][int'(cyc) * SPEED + g - TBLEN] <= dbit[g];

      if (last) begin
        sel   <= ~sel;
        drain <= DRW'(BLK);
      end else if (drain != '0) begin
        drain <= drain - 1'b1;
      end
    end
  end

  assign bit_valid = (drain != '0);
  assign bit_out   = stk[~sel][BBW'(drain - 1'b1)];

  AST_ONE_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |-> (!busy || last)); // R3
  AST_STACK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> (drain <= DRW'(1))); // R9
  AST_BURST_AFTER_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_valid) |-> $past(last)); // R6
  AST_QUIET_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> (done_cnt == DW'(SPEED - 1))); // R1
endmodule

// File: tb/tb_viterbi_traceback_mgr.sv
module tb_viterbi_traceback_mgr;
  localparam int N = 8, SP = 3, TB = 8;
  localparam int BLK = TB / (SP - 1);
  localparam int LAT = (SP + 1) * TB / (SP - 1) - 1;

  logic clk = 0, rst_n = 0, dec_valid = 0, bit_valid, bit_out;
  logic [N-1:0] dec_vec = '0;
  always #5 clk = ~clk;

  viterbi_traceback_mgr #(.STATES(N), .SPEED(SP), .TBLEN(TB)) dut (.*);

  int total = 0, bad = 0, cycnt = 0, ng = 0, first_in = 0, first_out = -1, run = 0, badrun = 0;
  logic [N-1:0] hist [256];
  logic got [256];
  logic expb [256];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always @(posedge clk) cycnt <= cycnt + 1;

  always @(negedge clk) begin
    if (bit_valid) begin
      if (ng < 256) got[ng] = bit_out;
      if (ng == 0) first_out = cycnt;
      ng++; run++;
    end else begin
      if (run % BLK != 0) badrun++;
      run = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] pat(input int mode, input int i);
    case (mode)
      0: return '0;
      1: return '1;
      4: return i[0] ? 8'h55 : 8'hAA;
      default: begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr[N-1:0];
      end
    endcase
  endfunction

  task automatic seg(input string req, input int mode, input int nw, input bit gaps);
    logic [2:0] s;
    logic d;
    int nexp;
    rst_n = 0; dec_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    ng = 0; first_out = -1; badrun = 0; run = 0;
    @(negedge clk);
    chk("R1 reset bit_valid", bit_valid, 0);
    for (int i = 0; i < nw; i++) begin
      if (gaps) while (lfsr[3:2] == 2'b00) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        dec_valid = 0;
        @(negedge clk);
      end
      hist[i] = pat(mode, i);
      dec_valid = 1; dec_vec = hist[i];
      if (i == 0) first_in = cycnt + 1;
      @(negedge clk);
    end
    dec_valid = 0;
    repeat (3 * BLK + 4) @(negedge clk);
    nexp = (nw / BLK >= SP) ? (nw / BLK - (SP - 1)) * BLK : 0;
    for (int c = SP * BLK - 1; c < nw; c += BLK) begin
      s = '0;
      for (int j = 0; j < SP * BLK; j++) begin
        d = hist[c - j][s];
        s = {d, s[2:1]};
        if (j >= TB) expb[c - j] = d;
      end
    end
    chk({req, " R4 bit count"}, ng, nexp);
    chk("R6 burst runs multiple of block", badrun, 0);
    for (int i = 0; i < nexp && i < ng; i++)
      chk({req, " R2 R3 R4 R8 R9 bit"}, int'(got[i]), int'(expb[i]));
    if (!gaps && nexp > 0) chk("R5 first-bit latency", first_out - first_in, LAT);
  endtask

  initial begin
    seg("R1 short", 3, 8, 0);
    seg("zeros", 0, 32, 0);
    seg("ones", 1, 32, 0);
    seg("alternating", 4, 40, 0);
    seg("random", 3, 64, 0);
    seg("R7 random gaps", 3, 64, 1);
    seg("R7 random gaps2", 3, 48, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule